// File: doc/BRIEF.md
# Latched-Input Parallel-to-Serial Shifter

The block captures a parallel word into a storage stage and then moves it out one bit at a time through a shift register. The storage stage has its own active-low enable. While that enable is low, the stage is transparent. While it is high, the stage holds its value. This lets a fresh word be captured while the previous word is still being serialised.

An active-low parallel load copies the storage stage into the shift register. An active-low clear zeroes the shift register. Both act at the level, on every system clock cycle, and both take priority over shifting. When load and clear are low together, clear wins and a flag reports the illegal combination.

Shifting is requested with a slow shift-clock input. That input is synchronised to the system clock, and each detected rising edge moves the register by one place. The serial output is the top stage.

Top module: `latched_piso`

## Requirements
- R1: While `latchEnN` is 0, the storage stage takes `dataIn` on every system clock edge.
- R2: While `latchEnN` is 1, the storage stage keeps its value whatever `dataIn` does.
- R3: While `loadN` is 0 and `clearN` is 1, the shift register is set to the storage stage on each clock edge, and any shift request is discarded.
- R4: A load in the same cycle as a capture (`latchEnN` = 0) loads the word present on `dataIn` in that cycle.
- R5: While `clearN` is 0, the shift register becomes all zeros on each clock edge, whatever `loadN` or the shift clock do.
- R6: `illegalFlag` is 1 in the cycle after an edge at which `loadN` and `clearN` were both 0, and is 0 otherwise.
- R7: A low `clearN` leaves the storage stage unchanged. A later load with the latch held brings back the word captured before the clear.
- R8: A rising edge of `shiftClk` causes exactly one shift, on the third system clock edge after the rise (two synchroniser stages, then edge detection). In that shift, stage k+1 takes stage k and stage 0 takes `serIn`.
- R9: `serOut` is the top stage (bit WIDTH-1). After a load, successive shifts present the loaded bits from bit WIDTH-1 down to bit 0.
- R10: Holding `shiftClk` high for many cycles yields only one shift.
- R11: While `rstN` is 0, the storage stage, the shift register, the synchroniser and `illegalFlag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous system reset, active low |
| dataIn | input | WIDTH | Parallel data word |
| latchEnN | input | 1 | Storage stage enable, active low (transparent when 0) |
| loadN | input | 1 | Parallel load from storage, active low, level sensitive |
| clearN | input | 1 | Shift register clear, active low, level sensitive |
| serIn | input | 1 | Serial data entering stage 0 |
| shiftClk | input | 1 | Asynchronous shift clock, rising edge shifts |
| serOut | output | 1 | Serial output, top stage of the shift register |
| illegalFlag | output | 1 | Load and clear were asserted together in the previous cycle |

## Verification
The hardest case to reach from the ports is a shift-clock edge whose detected strobe lands exactly while load or clear is active. The strobe appears three system cycles after the pin rises, so it is easy to miss.

The stimulus raises `shiftClk` and then asserts `loadN` (or `clearN`) across the whole synchroniser window. This guarantees that the strobe meets the overriding control.

A second hard case is reaching the storage stage through a clear. A word is captured, the latch is closed, and the register is cleared (once alone and once together with load). Then a load with the latch held has to bring the old word back out bit by bit.

// File: rtl/latched_piso_pkg.sv
package latched_piso_pkg;
  typedef struct packed {
    logic captureEn;
    logic clearEn;
    logic loadEn;
    logic shiftEn;
  } pisoStrobes_t;
endpackage

// File: rtl/latched_piso_ctrl.sv
module latched_piso_ctrl
  import latched_piso_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         latchEnN,
  input  logic         loadN,
  input  logic         clearN,
  input  logic         shiftClk,
  output pisoStrobes_t strobes,
  output logic         illegalFlag
);
  // syncQ[0..SYNC_STAGES-1] synchronise, syncQ[SYNC_STAGES] remembers last level
  logic [SYNC_STAGES:0] syncQ;
  logic                 edgeSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ       <= '0;
      illegalFlag <= 1'b0;
    end else begin
      syncQ       <= {syncQ[SYNC_STAGES-1:0], shiftClk};
      illegalFlag <= !loadN && !clearN;
    end
  end

  assign edgeSeen = syncQ[SYNC_STAGES-1] && !syncQ[SYNC_STAGES];

  // priority: clear, then load, then shift
  always_comb begin
    strobes.captureEn = !latchEnN;
    strobes.clearEn   = !clearN;
    strobes.loadEn    = !loadN && clearN;
    strobes.shiftEn   = edgeSeen && clearN && loadN;
  end
endmodule

// File: rtl/latched_piso_dp.sv
module latched_piso_dp
  import latched_piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  pisoStrobes_t     strobes,
  input  logic [WIDTH-1:0] dataIn,
  input  logic             serIn,
  output logic [WIDTH-1:0] storeQ,
  output logic [WIDTH-1:0] regQ
);
  logic [WIDTH-1:0] storeNext;
  logic [WIDTH-1:0] shifted;

  assign storeNext = strobes.captureEn ? dataIn : storeQ;

  genvar gi;
  generate
    for (gi = 1; gi < WIDTH; gi++) begin : g_stage
      assign shifted[gi] = regQ[gi-1];
    end
  endgenerate
  assign shifted[0] = serIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) storeQ <= '0;
    else       storeQ <= storeNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  regQ <= '0;
    else if (strobes.clearEn)   regQ <= '0;
    else if (strobes.loadEn)    regQ <= storeNext;
    else if (strobes.shiftEn)   regQ <= shifted;
  end
endmodule

// File: rtl/latched_piso.sv
module latched_piso
  import latched_piso_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dataIn,
  input  logic             latchEnN,
  input  logic             loadN,
  input  logic             clearN,
  input  logic             serIn,
  input  logic             shiftClk,
  output logic             serOut,
  output logic             illegalFlag
);
  localparam int TOP = WIDTH - 1;

  pisoStrobes_t     strobes;
  logic [WIDTH-1:0] storeQ;
  logic [WIDTH-1:0] regQ;

  latched_piso_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .latchEnN(latchEnN), .loadN(loadN),
    .clearN(clearN), .shiftClk(shiftClk), .strobes(strobes),
    .illegalFlag(illegalFlag)
  );

  latched_piso_dp #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .dataIn(dataIn),
    .serIn(serIn), .storeQ(storeQ), .regQ(regQ)
  );

  assign serOut = regQ[TOP];
endmodule

// File: rtl/latched_piso_chk.sv
module latched_piso_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             dataMsb,
  input logic             latchEnN,
  input logic             loadN,
  input logic             clearN,
  input logic             serIn,
  input logic             serOut,
  input logic             illegalFlag,
  input logic [WIDTH-1:0] storeQ,
  input logic [WIDTH-1:0] regQ,
  input logic             shiftEn,
  input logic             loadEn,
  input logic             clearEn
);
  a_r5_clear_zeroes: assert property (@(posedge clk) disable iff (!rstN)
    !clearN |=> (regQ == '0));

  a_r6_flag_set: assert property (@(posedge clk) disable iff (!rstN)
    (!loadN && !clearN) |=> illegalFlag);

  a_r6_flag_clear: assert property (@(posedge clk) disable iff (!rstN)
    !(!loadN && !clearN) |=> !illegalFlag);

  a_r4_load_transparent: assert property (@(posedge clk) disable iff (!rstN)
    (clearN && !loadN && !latchEnN) |=> (serOut == $past(dataMsb)));

  a_r3_load_from_store: assert property (@(posedge clk) disable iff (!rstN)
    (clearN && !loadN && latchEnN) |=> (regQ == $past(storeQ)));

  a_r2_store_holds: assert property (@(posedge clk) disable iff (!rstN)
    latchEnN |=> $stable(storeQ));

  a_r8_shift_step: assert property (@(posedge clk) disable iff (!rstN)
    shiftEn |=> (regQ == {$past(regQ[WIDTH-2:0]), $past(serIn)}));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!shiftEn && !loadEn && !clearEn) |=> $stable(regQ));

  a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    shiftEn |=> !shiftEn);
endmodule

bind latched_piso latched_piso_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .dataMsb(dataIn[WIDTH-1]), .latchEnN(latchEnN),
  .loadN(loadN), .clearN(clearN), .serIn(serIn), .serOut(serOut),
  .illegalFlag(illegalFlag), .storeQ(storeQ), .regQ(regQ),
  .shiftEn(strobes.shiftEn), .loadEn(strobes.loadEn), .clearEn(strobes.clearEn)
);

// File: tb/latched_piso_test.sv
module latched_piso_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] dataIn = '0;
  logic         latchEnN = 1'b1;
  logic         loadN = 1'b1;
  logic         clearN = 1'b1;
  logic         serIn = 1'b0;
  logic         shiftClk = 1'b0;
  logic         serOut;
  logic         illegalFlag;

  int compared = 0;
  int mismatched = 0;

  // behavioural model state
  logic [W-1:0] mStore = '0;
  logic [W-1:0] mReg = '0;
  logic         mS0 = 1'b0, mS1 = 1'b0, mPrev = 1'b0;
  string        curTag = "R11";

  logic  qSo[$];
  logic  qFl[$];
  string qTag[$];

  always #2.5 clk = ~clk;

  latched_piso #(.WIDTH(W)) uut (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .latchEnN(latchEnN),
    .loadN(loadN), .clearN(clearN), .serIn(serIn), .shiftClk(shiftClk),
    .serOut(serOut), .illegalFlag(illegalFlag)
  );

  task automatic check(string tag, logic act, logic exp, string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // driver: one system clock, model update, push expectation
  task automatic step();
    logic         edgeNow;
    logic [W-1:0] nStore;
    @(posedge clk);
    edgeNow = mS1 && !mPrev;
    mPrev = mS1; mS1 = mS0; mS0 = shiftClk;
    nStore = latchEnN ? mStore : dataIn;
    if (!clearN)      mReg = '0;
    else if (!loadN)  mReg = nStore;
    else if (edgeNow) mReg = {mReg[W-2:0], serIn};
    mStore = nStore;
    qSo.push_back(mReg[W-1]);
    qFl.push_back(!loadN && !clearN);
    qTag.push_back(curTag);
    @(negedge clk);
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  // one shift-clock pulse, serial input held across the whole detection window
  task automatic shiftPulse(logic s);
    serIn = s; shiftClk = 1'b1;
    steps(2);
    shiftClk = 1'b0;
    steps(3);
  endtask

  // monitor: compare every cycle's output with the scoreboard
  always @(negedge clk) begin
    if (qSo.size() > 0) begin
      logic  eSo, eFl;
      string t;
      eSo = qSo.pop_front(); eFl = qFl.pop_front(); t = qTag.pop_front();
      check(t, serOut, eSo, "serOut");
      check((t == "R6") ? "R6" : {t, "/R6"}, illegalFlag, eFl, "illegalFlag");
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R11: reset state
    dataIn = 8'hFF; latchEnN = 1'b0; loadN = 1'b0;
    repeat (3) @(negedge clk);
    check("R11", serOut, 1'b0, "serOut in reset");
    check("R11", illegalFlag, 1'b0, "flag in reset");
    latchEnN = 1'b1; loadN = 1'b1; dataIn = '0;
    @(negedge clk);
    rstN = 1'b1;
    curTag = "R11"; steps(2);

    // R1/R2/R3/R9: capture A5, close latch, change inputs, load, shift out
    curTag = "R1"; dataIn = 8'hA5; latchEnN = 1'b0; steps(2);
    latchEnN = 1'b1; curTag = "R2"; dataIn = 8'h3C; steps(3);
    curTag = "R3"; loadN = 1'b0; steps(1); loadN = 1'b1; steps(1);
    curTag = "R9";
    for (int i = 0; i < W; i++) shiftPulse(i[0]);
    curTag = "R8";
    for (int i = 0; i < W; i++) shiftPulse(~i[1]);

    // R4: capture and load in the same cycle
    curTag = "R4"; dataIn = 8'h81; latchEnN = 1'b0; loadN = 1'b0; steps(1);
    loadN = 1'b1; latchEnN = 1'b1; dataIn = 8'h00; steps(1);
    curTag = "R9";
    for (int i = 0; i < W; i++) shiftPulse(1'b0);

    // R3: shift request during load is discarded
    curTag = "R4"; dataIn = 8'h6E; latchEnN = 1'b0; steps(1); latchEnN = 1'b1;
    curTag = "R3"; shiftClk = 1'b1; serIn = 1'b1; loadN = 1'b0; steps(4);
    loadN = 1'b1; shiftClk = 1'b0; steps(3);
    curTag = "R9";
    for (int i = 0; i < 3; i++) shiftPulse(1'b1);

    // R10: shift clock held high
    curTag = "R10"; serIn = 1'b0; shiftClk = 1'b1; steps(20);
    shiftClk = 1'b0; steps(4);

    // R5: clear overrides shift edge
    curTag = "R5"; shiftClk = 1'b1; clearN = 1'b0; steps(4);
    clearN = 1'b1; shiftClk = 1'b0; steps(3);

    // R7: storage retained across clear (6E captured earlier)
    curTag = "R7"; loadN = 1'b0; steps(1); loadN = 1'b1; steps(1);
    curTag = "R5"; clearN = 1'b0; dataIn = 8'hFF; steps(2); clearN = 1'b1; steps(1);
    curTag = "R7"; loadN = 1'b0; steps(1); loadN = 1'b1; steps(1);
    for (int i = 0; i < W; i++) shiftPulse(1'b0);

    // R6: load and clear together, clear wins, flag one cycle later
    curTag = "R7"; loadN = 1'b0; steps(1); loadN = 1'b1; steps(1);
    curTag = "R6"; loadN = 1'b0; clearN = 1'b0; steps(2);
    loadN = 1'b1; clearN = 1'b1; steps(2);
    curTag = "R7"; loadN = 1'b0; steps(1); loadN = 1'b1; steps(1);
    for (int i = 0; i < W; i++) shiftPulse(1'b1);

    // R1: transparent latch with load held, msb follows dataIn each cycle
    curTag = "R1"; latchEnN = 1'b0; loadN = 1'b0;
    for (int i = 0; i < 6; i++) begin
      dataIn = {i[0], 7'h15}; steps(1);
    end
    loadN = 1'b1; latchEnN = 1'b1; steps(2);

    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule